// File: doc/BRIEF.md
# Dual-Mode Privilege Trap Unit

This unit holds the single hardware mode bit of a processor core and judges every decoded operation against it. The mode bit reads 0 in kernel mode and 1 in user mode. Each cycle the decoder presents an operation class with a valid strobe. The unit answers in that same cycle with an execute-allowed signal. User mode may run only the unprivileged classes. Kernel mode may run every class.

Any of three events moves the core into kernel mode through one shared trap path: a privileged operation attempted in user mode, a system-call trap, or an external interrupt. The unit then raises a one-cycle exception pulse with a cause code. The trap sequencer uses that pulse to fetch the vector and save context. An explicit return command issued in kernel mode drops the core back to user mode. The same command issued from user mode counts as a violation.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset the mode bit is 0 (kernel), the exception pulse is low and the cause code is 0.
- R2: In kernel mode, execute-allowed equals the valid strobe for every operation class 0 to 7. With the strobe low, execute-allowed is 0 in either mode.
- R3: In user mode, classes 0 (plain compute) and 1 (clock read) are allowed. Classes 2 (timer set), 3 (memory-map register write), 4 (I/O), 5 (halt), 6 (interrupt disable) and 7 (kernel entry) have execute-allowed low in the same cycle as the request.
- R4: A blocked privileged request in user mode makes the next cycle show mode 0, pulse 1 and cause 1 (violation).
- R5: A system-call request in either mode makes the next cycle show mode 0, pulse 1 and cause 2.
- R6: An interrupt request in either mode makes the next cycle show mode 0, pulse 1 and cause 3.
- R7: A return command in kernel mode with no event in the same cycle sets the mode bit to 1 in the next cycle, and no pulse is raised.
- R8: A return command in user mode is a violation: the next cycle shows mode 0, pulse 1 and cause 1.
- R9: Events in the same cycle are ranked violation first, then system call, then interrupt. Any event overrides a return command that arrives with it, so the mode stays at 0.
- R10: The pulse lasts one cycle per event cycle. The cause code reads 0 whenever the pulse is low, and the mode bit changes only through an event or a return command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | A decoded operation is presented this cycle |
| opClass | input | OP_W (3) | Class code of the presented operation |
| sysReq | input | 1 | System-call trap request |
| irqReq | input | 1 | External interrupt request |
| retUser | input | 1 | Return-to-user command |
| userMode | output | 1 | Mode bit: 0 kernel, 1 user |
| excPulse | output | 1 | One-cycle exception strobe |
| excCause | output | 2 | 0 none, 1 violation, 2 system call, 3 interrupt |
| execAllowed | output | 1 | The presented operation may execute |

## Verification
The bench runs every class in both modes. A decoder with an off-by-one privileged mask would let a timer set through in user mode, or would block a clock read. It sends a return command from user mode. A design that simply ignores that command would never pulse. It also drives coincident violation, system call, interrupt and return inputs. A wrong priority order shows up as the wrong cause code, and a return that wins over an event leaves the core in user mode. Idle cycles after each trap catch a pulse that sticks high or a cause code that keeps a stale value.

// File: rtl/priv_pkg.sv
`timescale 1ns/1ps
package priv_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_VIOL    = 2'd1,
    CAUSE_SYSCALL = 2'd2,
    CAUSE_IRQ     = 2'd3
  } cause_t;

  // strobes from control to the mode/exception datapath
  typedef struct packed {
    logic   raise;   // take the trap path into kernel mode
    logic   toUser;  // granted return to user mode
    cause_t cause;
  } strobe_t;
endpackage

// File: rtl/priv_class_dec.sv
`timescale 1ns/1ps
module priv_class_dec #(
  parameter int OP_W = 3,
  parameter logic [(1<<OP_W)-1:0] PRIV_MASK = 8'b1111_1100
) (
  input  logic [OP_W-1:0] opClass,
  output logic            isPriv
);
  localparam int NCLS = 1 << OP_W;

  logic [NCLS-1:0] hit;

  for (genvar i = 0; i < NCLS; i++) begin : g_cls
    assign hit[i] = (opClass == OP_W'(i)) && PRIV_MASK[i];
  end

  assign isPriv = |hit;
endmodule

// File: rtl/priv_ctrl.sv
`timescale 1ns/1ps
module priv_ctrl
  import priv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  logic    isPriv,
  input  logic    sysReq,
  input  logic    irqReq,
  input  logic    retUser,
  input  logic    userMode,
  output strobe_t stb,
  output logic    execAllowed
);
  logic violation;

  always_comb begin
    violation   = userMode && ((opValid && isPriv) || retUser);
    execAllowed = opValid && (!userMode || !isPriv);
    stb.raise   = violation || sysReq || irqReq;
    if (violation)   stb.cause = CAUSE_VIOL;
    else if (sysReq) stb.cause = CAUSE_SYSCALL;
    else if (irqReq) stb.cause = CAUSE_IRQ;
    else             stb.cause = CAUSE_NONE;
    stb.toUser  = retUser && !userMode && !stb.raise;
  end

  // R3
  user_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (userMode && opValid && isPriv) |-> (!execAllowed && stb.raise));

  // R9
  viol_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (userMode && retUser && (sysReq || irqReq)) |-> (stb.cause == CAUSE_VIOL));

  // R9
  event_beats_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysReq || irqReq) |-> !stb.toUser);
endmodule

// File: rtl/priv_dp.sv
`timescale 1ns/1ps
module priv_dp
  import priv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    userMode,
  output logic    excPulse,
  output cause_t  excCause
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      userMode <= 1'b0;
      excPulse <= 1'b0;
      excCause <= CAUSE_NONE;
    end else begin
      if (stb.raise)       userMode <= 1'b0;
      else if (stb.toUser) userMode <= 1'b1;
      excPulse <= stb.raise;
      excCause <= stb.raise ? stb.cause : CAUSE_NONE;
    end
  end

  // R4
  trap_enters_kernel_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.raise |=> (!userMode && excPulse));

  // R7
  return_to_user_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.toUser |=> (userMode && !excPulse));

  // R10
  quiet_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !excPulse |-> (excCause == CAUSE_NONE));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.raise && !stb.toUser) |=> $stable(userMode));
endmodule

// File: rtl/priv_trap_unit.sv
`timescale 1ns/1ps
module priv_trap_unit
  import priv_pkg::*;
#(
  parameter int OP_W = 3,
  parameter logic [(1<<OP_W)-1:0] PRIV_MASK = 8'b1111_1100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            opValid,
  input  logic [OP_W-1:0] opClass,
  input  logic            sysReq,
  input  logic            irqReq,
  input  logic            retUser,
  output logic            userMode,
  output logic            excPulse,
  output logic [1:0]      excCause,
  output logic            execAllowed
);
  logic    isPriv;
  strobe_t stb;
  cause_t  causeQ;

  priv_class_dec #(.OP_W(OP_W), .PRIV_MASK(PRIV_MASK)) u_dec (
    .opClass (opClass),
    .isPriv  (isPriv)
  );

  priv_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .isPriv      (isPriv),
    .sysReq      (sysReq),
    .irqReq      (irqReq),
    .retUser     (retUser),
    .userMode    (userMode),
    .stb         (stb),
    .execAllowed (execAllowed)
  );

  priv_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .userMode (userMode),
    .excPulse (excPulse),
    .excCause (causeQ)
  );

  assign excCause = causeQ;

  // R2
  idle_no_exec_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !execAllowed);

  // R5
  syscall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysReq && !userMode) |=> (excPulse && excCause == 2'd2 && !userMode));
endmodule

// File: tb/priv_trap_unit_test.sv
`timescale 1ns/1ps
module priv_trap_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN, opValid, sysReq, irqReq, retUser;
  logic [2:0] opClass;
  logic       userMode, excPulse, execAllowed;
  logic [1:0] excCause;

  priv_trap_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass),
    .sysReq(sysReq), .irqReq(irqReq), .retUser(retUser),
    .userMode(userMode), .excPulse(excPulse), .excCause(excCause),
    .execAllowed(execAllowed)
  );

  typedef struct {
    logic       m;
    logic       p;
    logic [1:0] c;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  logic mMode = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, same-cycle permission check, push expected registered result
  task automatic step(input logic v, input logic [2:0] cls, input logic s,
                      input logic i, input logic r, input string tag);
    logic viol, expExec;
    exp_t e;
    @(negedge clk);
    opValid = v; opClass = cls; sysReq = s; irqReq = i; retUser = r;
    #1;
    expExec = v && (!mMode || cls < 3'd2);
    check({tag, " exec"}, int'(execAllowed), int'(expExec));
    viol = (v && mMode && cls >= 3'd2) || (r && mMode);
    e.c = viol ? 2'd1 : s ? 2'd2 : i ? 2'd3 : 2'd0;
    e.p = (e.c != 2'd0);
    if (e.p) mMode = 1'b0;
    else if (r && !mMode) mMode = 1'b1;
    e.m = mMode;
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare registered outputs one cycle after each driven cycle
  always @(posedge clk) begin : mon
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check({e.tag, " mode"},  int'(userMode), int'(e.m));
      check({e.tag, " pulse"}, int'(excPulse), int'(e.p));
      check({e.tag, " cause"}, int'(excCause), int'(e.c));
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0; opValid = 1'b0; opClass = 3'd0;
    sysReq = 1'b0; irqReq = 1'b0; retUser = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode",  int'(userMode), 0);
    check("R1 pulse", int'(excPulse), 0);
    check("R1 cause", int'(excCause), 0);
    check("R2 idle exec in reset", int'(execAllowed), 0);
    rstN = 1'b1;

    // R2 every class in kernel mode
    for (int c = 0; c < 8; c++) step(1'b1, 3'(c), 1'b0, 1'b0, 1'b0, "R2 kernel class");
    step(1'b0, 3'd4, 1'b0, 1'b0, 1'b0, "R2 no valid");

    // R7 enter user mode
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R7 return");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R10 idle user");

    // R3 / R4 every class in user mode
    for (int c = 0; c < 8; c++) begin
      step(1'b1, 3'(c), 1'b0, 1'b0, 1'b0, (c < 2) ? "R3 user allowed" : "R4 user blocked");
      if (c >= 2) begin
        step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R10 pulse drops");
        step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R7 return again");
      end
    end
    step(1'b0, 3'd2, 1'b0, 1'b0, 1'b0, "R2 no valid user");

    // R5 system call from user and from kernel
    step(1'b1, 3'd1, 1'b1, 1'b0, 1'b0, "R5 syscall user");
    step(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, "R5 syscall kernel");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R10 idle");

    // R6 interrupt from user and from kernel
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R7 return");
    step(1'b0, 3'd0, 1'b0, 1'b1, 1'b0, "R6 irq user");
    step(1'b1, 3'd5, 1'b0, 1'b1, 1'b0, "R6 irq kernel");

    // R8 return issued in user mode
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R7 return");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R8 return in user");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R10 idle");

    // R9 priority cases
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R7 return");
    step(1'b1, 3'd6, 1'b1, 1'b1, 1'b0, "R9 viol over syscall irq");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R7 return");
    step(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, "R9 viol by return over irq");
    step(1'b0, 3'd0, 1'b1, 1'b1, 1'b0, "R9 syscall over irq");
    step(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, "R9 irq beats return");
    step(1'b0, 3'd0, 1'b1, 1'b0, 1'b1, "R9 syscall beats return");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R10 idle");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, "R10 idle");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule